// File: doc/BRIEF.md
# Byte-Serial Sponge Hash Controller

This block drives an 88-bit sponge hash (8-bit rate, 80-bit capacity, 45-round permutation) from a narrow host bus. A host presents a data byte, a 3-bit address and two strobes. Writes to the message address fold a byte into the rate and run the permutation. Writes to the command address clear the sponge, copy the state out, or finish a message with built-in padding. A read strobe walks through the 11-byte digest one byte at a time.

The permutation takes two rounds per clock, so one permutation call plus its load and capture cycles occupies a fixed 25-cycle window. The host sees this window as `busy` and must wait for it to end before it issues the next write. The digest leaves through a shift register whose lowest byte is always on `dataOut`.

Top module: `sponge_hash`

## Requirements
- R1: While and after `rst_n` is low, `busy` and `outValid` are 0 and `dataOut` is 0x00.
- R2: A write of 0x00 to address 0 clears the 88-bit state and drops `outValid` on the next cycle. A later absorb then starts from an all-zero state.
- R3: A write of byte b to address 1 XORs b into state bits [7:0] and applies the full 45-round permutation. Each round XORs a 6-bit counter into bits [5:0] and, bit-reversed, into bits [87:82]. The counter is seeded with 0x05 and steps as c <= {c[4:0], c[5]^c[4]}. The round then applies the 4-bit S-box layer (E D B 0 2 1 4 F 7 A 8 5 9 C 3 6 for inputs 0..F) and moves bit i to (22*i) mod 87, with bit 87 fixed.
- R4: An accepted absorb or hash command holds `busy` high for exactly 25 consecutive cycles, starting the cycle after the clock edge that samples the strobe's rising edge.
- R5: A write of 0x01 to address 0 copies the state into the output register and sets `outValid` on the next cycle, without raising `busy`.
- R6: A write of 0x02 to address 0 absorbs the pad byte 0x81 as in R3. When `busy` falls, the new state is already in the output register and `outValid` is 1.
- R7: A rising edge of `rdStrobe` while `addr` is 2 shifts the output register down one byte. The 11 digest bytes appear on `dataOut` in order: state bits [7:0] first and bits [87:80] last. Zero bytes follow after that.
- R8: Writes act only on a 0-to-1 change of `wrStrobe` between two sampled cycles. A strobe held high starts nothing further.
- R9: A write strobe edge sampled while `busy` is high has no effect. This holds in the final busy cycle as well.
- R10: Once set, `outValid` stays 1 through absorbs and hashes until a clear command is accepted.
- R11: After a clear, absorbing 0x00 and then squeezing reads out 82 f3 ce cf 16 7f eb 39 81 c0 7c.
- R12: Writes to addresses 2 to 7, and command bytes other than 0x00 to 0x02, leave `busy`, `outValid`, the output register and the state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dataIn | input | 8 | Message byte or command code |
| addr | input | 3 | Register address (0 command, 1 message, 2 readout) |
| wrStrobe | input | 1 | Write strobe, acts on its rising edge |
| rdStrobe | input | 1 | Read strobe, acts on its rising edge at address 2 |
| dataOut | output | 8 | Lowest byte of the digest shift register |
| busy | output | 1 | High while a permutation call is in progress |
| outValid | output | 1 | High after a squeeze until the next clear |

## Verification
The hardest case to reach is a write edge that falls in the very last busy cycle, the capture cycle. There the control is about to return to idle, but the write must still be dropped. The bench counts falling-edge negedges from the start of an absorb and raises the strobe exactly 24 samples later, so the edge meets the capture edge. It also issues a second absorb in the middle of a run and holds a strobe high across a whole window. The digest read afterwards must match a single absorb, and the busy run must still be exactly 25 cycles long.

// File: rtl/sponge_pkg.sv
package sponge_pkg;

  localparam int STATE_W     = 88;
  localparam int RATE_W      = 8;
  localparam int CTR_W       = 6;
  localparam int ROUNDS      = 45;
  localparam int UNROLL      = 2;
  localparam int ADDR_W      = 3;
  localparam int NIBBLES     = STATE_W / 4;
  localparam int OUT_BYTES   = STATE_W / RATE_W;
  localparam int PERM_CYCLES = (ROUNDS + UNROLL - 1) / UNROLL;
  localparam int TAIL_ROUNDS = ROUNDS % UNROLL;
  localparam int BUSY_CYCLES = PERM_CYCLES + 2;
  localparam int STEP_W      = $clog2(PERM_CYCLES);

  localparam logic [CTR_W-1:0]  CTR_SEED = 6'h05;
  localparam logic [RATE_W-1:0] PAD_BYTE = 8'h81;

  localparam logic [ADDR_W-1:0] ADDR_CMD = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MSG = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_OUT = 3'd2;

  localparam logic [RATE_W-1:0] CMD_CLEAR   = 8'h00;
  localparam logic [RATE_W-1:0] CMD_SQUEEZE = 8'h01;
  localparam logic [RATE_W-1:0] CMD_HASH    = 8'h02;

  // strobes from control to datapath
  typedef struct packed {
    logic clearState;
    logic latchMsg;
    logic latchPad;
    logic startPerm;
    logic roundStep;
    logic shortStep;
    logic commit;
    logic squeeze;
    logic shiftOut;
  } dpCtrl_t;

  function automatic logic [3:0] sboxNib(input logic [3:0] x);
    case (x)
      4'h0: sboxNib = 4'hE;  4'h1: sboxNib = 4'hD;
      4'h2: sboxNib = 4'hB;  4'h3: sboxNib = 4'h0;
      4'h4: sboxNib = 4'h2;  4'h5: sboxNib = 4'h1;
      4'h6: sboxNib = 4'h4;  4'h7: sboxNib = 4'hF;
      4'h8: sboxNib = 4'h7;  4'h9: sboxNib = 4'hA;
      4'hA: sboxNib = 4'h8;  4'hB: sboxNib = 4'h5;
      4'hC: sboxNib = 4'h9;  4'hD: sboxNib = 4'hC;
      4'hE: sboxNib = 4'h3;  default: sboxNib = 4'h6;
    endcase
  endfunction

  function automatic logic [STATE_W-1:0] subLayer(input logic [STATE_W-1:0] s);
    logic [STATE_W-1:0] o;
    for (int n = 0; n < NIBBLES; n++) o[4*n +: 4] = sboxNib(s[4*n +: 4]);
    return o;
  endfunction

  function automatic logic [STATE_W-1:0] bitShuffle(input logic [STATE_W-1:0] s);
    logic [STATE_W-1:0] o;
    o[STATE_W-1] = s[STATE_W-1];
    for (int i = 0; i < STATE_W - 1; i++) o[(i * NIBBLES) % (STATE_W - 1)] = s[i];
    return o;
  endfunction

  function automatic logic [CTR_W-1:0] ctrStep(input logic [CTR_W-1:0] c);
    return {c[CTR_W-2:0], c[CTR_W-1] ^ c[CTR_W-2]};
  endfunction

  function automatic logic [STATE_W-1:0] oneRound(input logic [STATE_W-1:0] s,
                                                  input logic [CTR_W-1:0] c);
    logic [STATE_W-1:0] t;
    t = s;
    for (int j = 0; j < CTR_W; j++) begin
      t[j]           = t[j] ^ c[j];
      t[STATE_W-1-j] = t[STATE_W-1-j] ^ c[j];
    end
    return bitShuffle(subLayer(t));
  endfunction

endpackage

// File: rtl/sponge_ctrl.sv
module sponge_ctrl
  import sponge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] dataIn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrStrobe,
  input  logic              rdStrobe,
  output dpCtrl_t           ctl,
  output logic              busy,
  output logic              outValid
);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_PERM, ST_CAPT} ctrlState_t;

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PERM_CYCLES - 1);
  localparam logic              HAS_TAIL  = (TAIL_ROUNDS != 0);

  ctrlState_t        stQ, stNext;
  logic [STEP_W-1:0] stepQ, stepNext;
  logic              autoQ, autoNext;
  logic              validQ, validNext;
  logic              wrPrevQ, rdPrevQ;
  logic              wrEdge, rdEdge;

  assign wrEdge = wrStrobe & ~wrPrevQ;
  assign rdEdge = rdStrobe & ~rdPrevQ;

  always_comb begin
    ctl       = '0;
    stNext    = stQ;
    stepNext  = stepQ;
    autoNext  = autoQ;
    validNext = validQ;
    case (stQ)
      ST_IDLE: begin
        if (wrEdge) begin
          if (addr == ADDR_MSG) begin
            ctl.latchMsg = 1'b1;
            autoNext     = 1'b0;
            stNext       = ST_LOAD;
          end else if (addr == ADDR_CMD) begin
            case (dataIn)
              CMD_CLEAR: begin
                ctl.clearState = 1'b1;
                validNext      = 1'b0;
              end
              CMD_SQUEEZE: begin
                ctl.squeeze = 1'b1;
                validNext   = 1'b1;
              end
              CMD_HASH: begin
                ctl.latchPad = 1'b1;
                autoNext     = 1'b1;
                stNext       = ST_LOAD;
              end
              default: ;
            endcase
          end
        end
      end
      ST_LOAD: begin
        ctl.startPerm = 1'b1;
        stepNext      = '0;
        stNext        = ST_PERM;
      end
      ST_PERM: begin
        ctl.roundStep = 1'b1;
        if (stepQ == LAST_STEP) begin
          ctl.shortStep = HAS_TAIL;
          stNext        = ST_CAPT;
        end else begin
          stepNext = stepQ + 1'b1;
        end
      end
      default: begin
        ctl.commit = 1'b1;
        if (autoQ) begin
          ctl.squeeze = 1'b1;
          validNext   = 1'b1;
        end
        stNext = ST_IDLE;
      end
    endcase
    // a squeeze landing in the same cycle takes precedence over a shift
    ctl.shiftOut = rdEdge && (addr == ADDR_OUT) && !ctl.squeeze;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stQ     <= ST_IDLE;
      stepQ   <= '0;
      autoQ   <= 1'b0;
      validQ  <= 1'b0;
      wrPrevQ <= 1'b0;
      rdPrevQ <= 1'b0;
    end else begin
      stQ     <= stNext;
      stepQ   <= stepNext;
      autoQ   <= autoNext;
      validQ  <= validNext;
      wrPrevQ <= wrStrobe;
      rdPrevQ <= rdStrobe;
    end
  end

  assign busy     = (stQ != ST_IDLE);
  assign outValid = validQ;

endmodule

// File: rtl/sponge_dp.sv
module sponge_dp
  import sponge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtrl_t           ctl,
  input  logic [RATE_W-1:0] dataIn,
  output logic [RATE_W-1:0] dataOut
);

  localparam int TAIL_IDX = (TAIL_ROUNDS == 0) ? UNROLL : TAIL_ROUNDS;

  logic [STATE_W-1:0] stateQ, workQ, outQ;
  logic [CTR_W-1:0]   ctrQ;
  logic [RATE_W-1:0]  inByteQ;

  logic [STATE_W-1:0] stChain [UNROLL+1];
  logic [CTR_W-1:0]   ctChain [UNROLL+1];

  assign stChain[0] = workQ;
  assign ctChain[0] = ctrQ;

  // unrolled round chain: one stage per round handled in a cycle
  for (genvar g = 0; g < UNROLL; g++) begin : gRound
    assign stChain[g+1] = oneRound(stChain[g], ctChain[g]);
    assign ctChain[g+1] = ctrStep(ctChain[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ  <= '0;
      workQ   <= '0;
      outQ    <= '0;
      ctrQ    <= '0;
      inByteQ <= '0;
    end else begin
      if (ctl.clearState) stateQ <= '0;
      if (ctl.latchMsg) inByteQ <= dataIn;
      if (ctl.latchPad) inByteQ <= PAD_BYTE;
      if (ctl.startPerm) begin
        workQ <= stateQ ^ {{(STATE_W-RATE_W){1'b0}}, inByteQ};
        ctrQ  <= CTR_SEED;
      end
      if (ctl.roundStep) begin
        if (ctl.shortStep) begin
          workQ <= stChain[TAIL_IDX];
          ctrQ  <= ctChain[TAIL_IDX];
        end else begin
          workQ <= stChain[UNROLL];
          ctrQ  <= ctChain[UNROLL];
        end
      end
      if (ctl.commit) stateQ <= workQ;
      if (ctl.squeeze) outQ <= ctl.commit ? workQ : stateQ;
      else if (ctl.shiftOut) outQ <= outQ >> RATE_W;
    end
  end

  assign dataOut = outQ[RATE_W-1:0];

endmodule

// File: rtl/sponge_hash.sv
module sponge_hash
  import sponge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] dataIn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrStrobe,
  input  logic              rdStrobe,
  output logic [RATE_W-1:0] dataOut,
  output logic              busy,
  output logic              outValid
);

  dpCtrl_t ctl;

  sponge_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .dataIn   (dataIn),
    .addr     (addr),
    .wrStrobe (wrStrobe),
    .rdStrobe (rdStrobe),
    .ctl      (ctl),
    .busy     (busy),
    .outValid (outValid)
  );

  sponge_dp u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ctl),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );

endmodule

// File: rtl/sponge_hash_chk.sv
module sponge_hash_chk
  import sponge_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [RATE_W-1:0] dataIn,
  input logic [ADDR_W-1:0] addr,
  input logic              wrStrobe,
  input logic              busy,
  input logic              outValid
);

  logic       wrPrevC;
  logic [7:0] busyRun;
  logic       hashRun;
  logic       wrEdgeC, acceptC, accClear, accSqueeze, accAbsorb, accHash, accOther;

  assign wrEdgeC    = wrStrobe && !wrPrevC;
  assign acceptC    = wrEdgeC && !busy;
  assign accClear   = acceptC && addr == ADDR_CMD && dataIn == CMD_CLEAR;
  assign accSqueeze = acceptC && addr == ADDR_CMD && dataIn == CMD_SQUEEZE;
  assign accHash    = acceptC && addr == ADDR_CMD && dataIn == CMD_HASH;
  assign accAbsorb  = acceptC && addr == ADDR_MSG;
  assign accOther   = acceptC && (addr > ADDR_MSG || (addr == ADDR_CMD && dataIn > CMD_HASH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPrevC <= 1'b0;
      busyRun <= '0;
      hashRun <= 1'b0;
    end else begin
      wrPrevC <= wrStrobe;
      busyRun <= busy ? busyRun + 8'd1 : 8'd0;
      if (accHash) hashRun <= 1'b1;
      else if (!busy) hashRun <= hashRun && !accAbsorb ? hashRun : 1'b0;
    end
  end

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busyRun == 8'(BUSY_CYCLES)); // R4
  AST_BUSY_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busyRun < 8'(BUSY_CYCLES)); // R9
  AST_CLEAR_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    accClear |=> !outValid); // R2
  AST_SQUEEZE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    accSqueeze |=> outValid && !busy); // R5
  AST_ABSORB_START: assert property (@(posedge clk) disable iff (!rst_n)
    accAbsorb |=> busy); // R3
  AST_HASH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && hashRun) |-> outValid); // R6
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wrStrobe && wrPrevC && !busy) |=> !busy); // R8
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !accClear) |=> outValid); // R10
  AST_IGNORE_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    accOther |=> !busy && outValid == $past(outValid)); // R12

endmodule

bind sponge_hash sponge_hash_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dataIn   (dataIn),
  .addr     (addr),
  .wrStrobe (wrStrobe),
  .busy     (busy),
  .outValid (outValid)
);

// File: tb/sponge_hash_tb.sv
module sponge_hash_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  localparam logic [3:0] SB [16] = '{4'hE, 4'hD, 4'hB, 4'h0, 4'h2, 4'h1, 4'h4, 4'hF,
                                     4'h7, 4'hA, 4'h8, 4'h5, 4'h9, 4'hC, 4'h3, 4'h6};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic [2:0] addr = 3'd0;
  logic       wrStrobe = 1'b0;
  logic       rdStrobe = 1'b0;
  logic [7:0] dataOut;
  logic       busy;
  logic       outValid;

  int errors = 0;
  int checks = 0;
  bit timedOut = 1'b0;
  bit running = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sponge_hash u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .dataIn   (dataIn),
    .addr     (addr),
    .wrStrobe (wrStrobe),
    .rdStrobe (rdStrobe),
    .dataOut  (dataOut),
    .busy     (busy),
    .outValid (outValid)
  );

  // ---------------- behavioural reference ----------------
  function automatic logic [87:0] refPerm(input logic [87:0] s);
    logic [87:0] u, t;
    logic [5:0]  c = 6'h05;
    for (int r = 0; r < 45; r++) begin
      for (int j = 0; j < 6; j++) begin
        s[j]    ^= c[j];
        s[87-j] ^= c[j];
      end
      for (int n = 0; n < 22; n++) u[4*n +: 4] = SB[s[4*n +: 4]];
      for (int i = 0; i < 87; i++) t[(i * 22) % 87] = u[i];
      t[87] = u[87];
      s = t;
      c = {c[4:0], c[5] ^ c[4]};
    end
    return s;
  endfunction

  // state to output order: first read byte in the top bits
  function automatic logic [87:0] inReadOrder(input logic [87:0] s);
    logic [87:0] o;
    for (int k = 0; k < 11; k++) o[87-8*k -: 8] = s[8*k +: 8];
    return o;
  endfunction

  logic [87:0] mState, mPending;
  int          mBusyCnt;
  bit          mAuto, mValid, mWrPrev, mRdPrev;
  logic [7:0]  mOut[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      mState = '0; mPending = '0; mBusyCnt = 0; mAuto = 0; mValid = 0;
      mWrPrev = 0; mRdPrev = 0;
      mOut = {};
      for (int k = 0; k < 11; k++) mOut.push_back(8'h00);
    end else begin
      bit wrE, rdE, loaded;
      wrE = wrStrobe && !mWrPrev;
      rdE = rdStrobe && !mRdPrev;
      mWrPrev = wrStrobe;
      mRdPrev = rdStrobe;
      loaded = 0;
      if (mBusyCnt > 0) begin
        mBusyCnt--;
        if (mBusyCnt == 0) begin
          mState = mPending;
          if (mAuto) begin
            mOut = {};
            for (int k = 0; k < 11; k++) mOut.push_back(mState[8*k +: 8]);
            mValid = 1; loaded = 1;
          end
        end
      end else if (wrE) begin
        if (addr == 3'd1) begin
          mPending = refPerm(mState ^ {80'b0, dataIn}); mBusyCnt = 25; mAuto = 0;
        end else if (addr == 3'd0) begin
          if (dataIn == 8'h00) begin mState = '0; mValid = 0; end
          else if (dataIn == 8'h01) begin
            mOut = {};
            for (int k = 0; k < 11; k++) mOut.push_back(mState[8*k +: 8]);
            mValid = 1; loaded = 1;
          end else if (dataIn == 8'h02) begin
            mPending = refPerm(mState ^ 88'h81); mBusyCnt = 25; mAuto = 1;
          end
        end
      end
      if (rdE && addr == 3'd2 && !loaded) begin
        void'(mOut.pop_front());
        mOut.push_back(8'h00);
      end
    end
  end

  // cycle-by-cycle comparison against the reference (R3 R5 R6 R7 R9 R12)
  always @(negedge clk) begin
    if (running && rst_n) begin
      checks++;
      if (busy !== (mBusyCnt > 0) || outValid !== mValid || dataOut !== mOut[0]) begin
        errors++;
        $display("FAIL R3 R6 R7 R9 R12 model: busy=%0b/%0b valid=%0b/%0b out=%02h/%02h (actual/expected)",
                 busy, (mBusyCnt > 0), outValid, mValid, dataOut, mOut[0]);
      end
    end
  end

  // busy run length seen at negedges
  int busyRunTb = 0;
  int lastRun = 0;
  always @(negedge clk) begin
    if (busy) busyRunTb++;
    else if (busyRunTb != 0) begin lastRun = busyRunTb; busyRunTb = 0; end
  end

  // ---------------- tasks ----------------
  task automatic check(input bit ok, input string req, input logic [87:0] act, input logic [87:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; dataIn = d; wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic readDigest(output logic [87:0] got);
    for (int k = 0; k < 11; k++) begin
      got[87-8*k -: 8] = dataOut;
      @(negedge clk);
      addr = 3'd2; rdStrobe = 1'b1;
      @(negedge clk);
      rdStrobe = 1'b0;
    end
  endtask

  task automatic absorbByte(input logic [7:0] b);
    writeReg(3'd1, b);
    waitIdle();
  endtask

  // ---------------- stimulus ----------------
  task automatic runTests();
    logic [87:0] got, exp, st;
    logic [7:0]  katIn [5] = '{8'h00, 8'h01, 8'h80, 8'hFF, 8'hA5};
    logic [87:0] katOut [5] = '{88'h82f3cecf167feb3981c07c, 88'h0842dc1b6c7399eb92f540,
                                88'ha0623e32cd5a6bba0b304f, 88'hfe511649a2fa375bf97aa3,
                                88'h82b032622cbefe65b01911};

    repeat (3) @(negedge clk);
    check(busy === 1'b0 && outValid === 1'b0 && dataOut === 8'h00, "R1 reset outputs",
          {busy, outValid, dataOut}, 0);
    rst_n = 1'b1;
    running = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && outValid === 1'b0, "R1 after release", {busy, outValid}, 0);

    // R11 / R4 / R5 / R7: known digest of a single zero byte
    writeReg(3'd0, 8'h00);
    absorbByte(8'h00);
    check(lastRun == 25, "R4 absorb busy length", lastRun, 25);
    writeReg(3'd0, 8'h01);
    check(outValid === 1'b1 && busy === 1'b0, "R5 squeeze flags", {busy, outValid}, 1);
    readDigest(got);
    check(got == katOut[0], "R11 zero-byte digest", got, katOut[0]);
    check(dataOut === 8'h00, "R7 zero fill after 11 reads", dataOut, 0);

    // R3: single-byte digests against fixed vectors and the reference
    for (int v = 1; v < 5; v++) begin
      writeReg(3'd0, 8'h00);
      absorbByte(katIn[v]);
      writeReg(3'd0, 8'h01);
      readDigest(got);
      check(got == katOut[v], "R3 single-byte vector", got, katOut[v]);
      exp = inReadOrder(refPerm({80'b0, katIn[v]}));
      check(got == exp, "R3 reference model", got, exp);
    end

    // R6: hash command with built-in padding after three bytes
    writeReg(3'd0, 8'h00);
    check(outValid === 1'b0, "R2 clear drops valid", outValid, 0);
    absorbByte(8'hAB);
    absorbByte(8'hCD);
    writeReg(3'd1, 8'hEF);
    waitIdle();
    writeReg(3'd0, 8'h02);
    while (busy) @(negedge clk);
    check(lastRun == 25, "R6 hash busy length", lastRun, 25);
    check(outValid === 1'b1, "R6 auto squeeze valid", outValid, 1);
    st = refPerm(refPerm(refPerm(refPerm(88'hAB) ^ 88'hCD) ^ 88'hEF) ^ 88'h81);
    readDigest(got);
    check(got == inReadOrder(st), "R6 padded digest", got, inReadOrder(st));

    // R10: valid survives absorbs, R2: clear restarts from zero
    absorbByte(8'h5A);
    check(outValid === 1'b1, "R10 valid sticky", outValid, 1);
    writeReg(3'd0, 8'h00);
    absorbByte(8'h00);
    writeReg(3'd0, 8'h01);
    readDigest(got);
    check(got == katOut[0], "R2 clear zeroes state", got, katOut[0]);

    // R9: write mid-run and in the capture cycle are dropped
    writeReg(3'd0, 8'h00);
    writeReg(3'd1, 8'h11);
    repeat (4) @(negedge clk);
    writeReg(3'd1, 8'h22);
    waitIdle();
    check(lastRun == 25, "R9 mid-run write dropped", lastRun, 25);
    writeReg(3'd1, 8'h33);
    repeat (23) @(negedge clk);
    writeReg(3'd1, 8'h44);
    check(busy === 1'b0, "R9 capture-cycle write dropped", busy, 0);
    repeat (2) @(negedge clk);
    check(busy === 1'b0, "R9 no late start", busy, 0);
    writeReg(3'd0, 8'h01);
    readDigest(got);
    exp = inReadOrder(refPerm(refPerm(88'h11) ^ 88'h33));
    check(got == exp, "R9 digest unaffected", got, exp);

    // R8: held strobe starts one absorb only
    @(negedge clk);
    addr = 3'd1; dataIn = 8'h77; wrStrobe = 1'b1;
    repeat (40) @(negedge clk);
    check(busy === 1'b0 && lastRun == 25, "R8 level hold single run", {busy, 8'(lastRun)}, 25);
    wrStrobe = 1'b0;
    @(negedge clk);

    // R12: stray addresses and command codes
    writeReg(3'd0, 8'h01);
    readDigest(got);
    writeReg(3'd0, 8'h01);
    writeReg(3'd5, 8'h00);
    writeReg(3'd0, 8'h03);
    writeReg(3'd2, 8'h02);
    writeReg(3'd7, 8'h01);
    check(busy === 1'b0 && outValid === 1'b1, "R12 flags unchanged", {busy, outValid}, 1);
    readDigest(exp);
    check(exp == got, "R12 output unchanged", exp, got);
    writeReg(3'd0, 8'h01);
    readDigest(exp);
    check(exp == got, "R12 state unchanged", exp, got);
  endtask

  initial begin
    fork
      runTests();
      begin
        repeat (WATCHDOG) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=expired expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule